// File: doc/BRIEF.md
# Command Stream Header Parser

This block sits at the input of a command-processing channel. It watches a stream of 32-bit command words and sorts each one into a header or a payload word. When a header arrives it decodes the operation code in the top four bits and the fields that go with that operation. It then works out how many payload words belong to the header, counts them down as they pass, and treats the word after the last one as the next header.

Each accepted word produces one registered decoded record one cycle later. The record gives the header/payload flag, the opcode, the active class, the register offset that word targets, a mask/count/data field, a restart target, and flags for lock acquire, lock release and unknown extended sub-operations. The record is held while the downstream stage stalls, and the input is back-pressured through a ready signal. Register writes, memory fetches for gathers and lock arbitration happen in later stages.

Top module: `cmd_hdr_parser`

## Requirements
- R1: The opcode is bits 31:28 of a header word. A word is a header exactly when no payload words of an earlier header are still outstanding, and the record reports this with out_is_hdr=1. Opcode codes: 0 set-class, 1 incrementing write, 2 non-incrementing write, 3 masked write, 4 immediate, 5 restart, 6 gather, 14 extended.
- R2: A set-class header (opcode 0) loads the class from bits 15:6, reports offset bits 27:16 and field = bits 5:0 zero-extended, and is followed by as many payload words as bits 5:0 has set bits (none when zero). The class persists until the next set-class header, and every later record reports it.
- R3: Incrementing and non-incrementing writes (opcodes 1 and 2) report offset bits 27:16 and field = bits 15:0, and are followed by bits 15:0 payload words. Payload words of opcode 1 report the offset plus the word index, modulo 4096. Payload words of opcode 2 report the fixed offset.
- R4: A masked write (opcode 3) reports offset bits 27:16 and field = the 16-bit mask in bits 15:0, and is followed by one payload word per set mask bit. Payload word k reports the offset plus the bit position of the k-th lowest set bit, modulo 4096. Set-class payloads step the same way through their 6-bit mask.
- R5: An immediate header (opcode 4) reports offset bits 27:16 and field = data bits 15:0, with no payload.
- R6: A restart header (opcode 5) has no payload and reports out_addr = the header word shifted left by 4 bits. out_addr is zero on every other record.
- R7: A gather header (opcode 6) reports offset bits 27:16 and field = bits 15:0 (insert flag bit 15, type flag bit 14, count bits 13:0), and is followed by exactly one payload word that reports the same offset.
- R8: An extended header (opcode 14) has no payload and reports field = lock index bits 7:0. If sub-operation bits 27:24 are 0 it raises out_lock_acq, if they are 1 it raises out_lock_rel, and otherwise it raises out_ext_err. At most one of these flags is set.
- R9: Any other opcode is a header with no payload, offset 0, field 0 and no flags.
- R10: A payload record has out_is_hdr=0, carries the opcode of its header and the current class, reports field = the number of payload words still to come after it, and never raises a lock or error flag, whatever its bit pattern.
- R11: Synchronous reset clears the outstanding payload count and the class to 0, so the first word after reset is a header and reports class 0. The output is not valid after reset.
- R12: A word is accepted when in_valid and in_ready are both high, and in_ready = !out_valid || out_ready. The record of an accepted word is valid on the next cycle. It stays valid and unchanged while out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can take a word |
| in_word | input | 32 | Command stream word |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Downstream takes the record |
| out_is_hdr | output | 1 | Record is a header (1) or payload (0) |
| out_opcode | output | 4 | Header opcode, or the owning header's opcode for payload |
| out_class | output | 10 | Active class |
| out_offset | output | 12 | Register offset targeted by this word |
| out_field | output | 16 | Mask/count/data for headers; words remaining for payload |
| out_addr | output | 32 | Restart target address |
| out_lock_acq | output | 1 | Lock acquire request |
| out_lock_rel | output | 1 | Lock release request |
| out_ext_err | output | 1 | Unknown extended sub-operation |
| out_word | output | 32 | Raw word of this record |

## Verification
The bench builds the parser with its default field widths: a 12-bit offset, a 10-bit class and a 16-bit count and mask. At these widths an incrementing write that starts at offset 0xFFE and carries four words shows the offset wrapping to zero. A mask with bit 15 set reaches the far end of the masked-write stepping. Payload words are chosen with header-like opcode bits, including extended-lock patterns, to show that they are never decoded. The same stream is replayed with random output stalls and input gaps. A reset partway through a payload shows the count and the class being cleared.

// File: rtl/cmd_hdr_pkg.sv
package cmd_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 4;
  localparam int OFS_W  = 12;
  localparam int CLS_W  = 10;
  localparam int FLD_W  = 16;
  localparam int SCM_W  = 6;
  localparam int IDX_W  = 8;

  localparam logic [OP_W-1:0] OPC_SETCL   = 4'h0;
  localparam logic [OP_W-1:0] OPC_INCR    = 4'h1;
  localparam logic [OP_W-1:0] OPC_NONINCR = 4'h2;
  localparam logic [OP_W-1:0] OPC_MASKW   = 4'h3;
  localparam logic [OP_W-1:0] OPC_IMM     = 4'h4;
  localparam logic [OP_W-1:0] OPC_RESTART = 4'h5;
  localparam logic [OP_W-1:0] OPC_GATHER  = 4'h6;
  localparam logic [OP_W-1:0] OPC_EXT     = 4'hE;

  localparam logic [3:0] SUB_ACQ = 4'h0;
  localparam logic [3:0] SUB_REL = 4'h1;
endpackage

// File: rtl/cmd_popcnt.sv
module cmd_popcnt #(
  parameter int W = 16,
  localparam int NW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [NW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + NW'(vec[i]);
  end
endmodule

// File: rtl/cmd_low_bit.sv
module cmd_low_bit #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  rest
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
  assign rest = mask & (mask - W'(1));
endmodule

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmd_hdr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [FLD_W-1:0]  plen,
  output logic [OFS_W-1:0]  hdr_ofs,
  output logic [FLD_W-1:0]  hdr_fld,
  output logic [WORD_W-1:0] hdr_addr,
  output logic [FLD_W-1:0]  mask_init,
  output logic              cls_load,
  output logic [CLS_W-1:0]  new_cls,
  output logic              acq,
  output logic              rel,
  output logic              err
);
  localparam int PS_W = $clog2(SCM_W + 1);
  localparam int PM_W = $clog2(FLD_W + 1);

  logic [OP_W-1:0] op;
  logic [3:0]      sub;
  logic [PS_W-1:0] pc_scm;
  logic [PM_W-1:0] pc_msk;

  assign op      = word[31:28];
  assign sub     = word[27:24];
  assign new_cls = word[15:6];

  cmd_popcnt #(.W(SCM_W)) u_pc_scm (.vec(word[SCM_W-1:0]), .cnt(pc_scm));
  cmd_popcnt #(.W(FLD_W)) u_pc_msk (.vec(word[FLD_W-1:0]), .cnt(pc_msk));

  always_comb begin
    plen      = '0;
    hdr_ofs   = '0;
    hdr_fld   = '0;
    hdr_addr  = '0;
    mask_init = '0;
    cls_load  = 1'b0;
    acq       = 1'b0;
    rel       = 1'b0;
    err       = 1'b0;
    case (op)
      OPC_SETCL: begin
        hdr_ofs   = word[27:16];
        hdr_fld   = FLD_W'(word[SCM_W-1:0]);
        mask_init = FLD_W'(word[SCM_W-1:0]);
        plen      = FLD_W'(pc_scm);
        cls_load  = 1'b1;
      end
      OPC_INCR, OPC_NONINCR: begin
        hdr_ofs = word[27:16];
        hdr_fld = word[15:0];
        plen    = word[15:0];
      end
      OPC_MASKW: begin
        hdr_ofs   = word[27:16];
        hdr_fld   = word[15:0];
        mask_init = word[15:0];
        plen      = FLD_W'(pc_msk);
      end
      OPC_IMM: begin
        hdr_ofs = word[27:16];
        hdr_fld = word[15:0];
      end
      OPC_RESTART: hdr_addr = {word[27:0], 4'b0000};
      OPC_GATHER: begin
        hdr_ofs = word[27:16];
        hdr_fld = word[15:0];
        plen    = FLD_W'(1);
      end
      OPC_EXT: begin
        hdr_fld = FLD_W'(word[IDX_W-1:0]);
        acq     = (sub == SUB_ACQ);
        rel     = (sub == SUB_REL);
        err     = (sub != SUB_ACQ) && (sub != SUB_REL);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmd_hdr_parser.sv
module cmd_hdr_parser
  import cmd_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_hdr,
  output logic [3:0]        out_opcode,
  output logic [9:0]        out_class,
  output logic [11:0]       out_offset,
  output logic [15:0]       out_field,
  output logic [31:0]       out_addr,
  output logic              out_lock_acq,
  output logic              out_lock_rel,
  output logic              out_ext_err,
  output logic [31:0]       out_word
);
  localparam int LIW = $clog2(FLD_W);

  logic              accept, pending;
  logic [FLD_W-1:0]  rem_q;
  logic [OP_W-1:0]   mode_q;
  logic [OFS_W-1:0]  base_q, step_q, pay_ofs;
  logic [FLD_W-1:0]  msk_q, msk_rest;
  logic [LIW-1:0]    low_idx;
  logic [CLS_W-1:0]  cls_q;

  logic [FLD_W-1:0]  d_plen, d_fld, d_mask;
  logic [OFS_W-1:0]  d_ofs;
  logic [WORD_W-1:0] d_addr;
  logic              d_cls_load, d_acq, d_rel, d_err;
  logic [CLS_W-1:0]  d_cls;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign pending  = (rem_q != '0);

  cmd_hdr_decode u_dec (
    .word(in_word), .plen(d_plen), .hdr_ofs(d_ofs), .hdr_fld(d_fld),
    .hdr_addr(d_addr), .mask_init(d_mask), .cls_load(d_cls_load),
    .new_cls(d_cls), .acq(d_acq), .rel(d_rel), .err(d_err)
  );

  cmd_low_bit #(.W(FLD_W)) u_low (.mask(msk_q), .idx(low_idx), .rest(msk_rest));

  always_comb begin
    case (mode_q)
      OPC_INCR:             pay_ofs = step_q;
      OPC_SETCL, OPC_MASKW: pay_ofs = base_q + OFS_W'(low_idx);
      default:              pay_ofs = base_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      rem_q        <= '0;
      cls_q        <= '0;
      mode_q       <= '0;
      base_q       <= '0;
      step_q       <= '0;
      msk_q        <= '0;
      out_is_hdr   <= 1'b0;
      out_opcode   <= '0;
      out_class    <= '0;
      out_offset   <= '0;
      out_field    <= '0;
      out_addr     <= '0;
      out_lock_acq <= 1'b0;
      out_lock_rel <= 1'b0;
      out_ext_err  <= 1'b0;
      out_word     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_word  <= in_word;
      if (!pending) begin
        out_is_hdr   <= 1'b1;
        out_opcode   <= in_word[31:28];
        out_class    <= d_cls_load ? d_cls : cls_q;
        out_offset   <= d_ofs;
        out_field    <= d_fld;
        out_addr     <= d_addr;
        out_lock_acq <= d_acq;
        out_lock_rel <= d_rel;
        out_ext_err  <= d_err;
        if (d_cls_load) cls_q <= d_cls;
        rem_q  <= d_plen;
        mode_q <= in_word[31:28];
        base_q <= d_ofs;
        step_q <= d_ofs;
        msk_q  <= d_mask;
      end else begin
        out_is_hdr   <= 1'b0;
        out_opcode   <= mode_q;
        out_class    <= cls_q;
        out_offset   <= pay_ofs;
        out_field    <= rem_q - FLD_W'(1);
        out_addr     <= '0;
        out_lock_acq <= 1'b0;
        out_lock_rel <= 1'b0;
        out_ext_err  <= 1'b0;
        rem_q        <= rem_q - FLD_W'(1);
        if (mode_q == OPC_INCR) step_q <= step_q + OFS_W'(1);
        if (mode_q == OPC_SETCL || mode_q == OPC_MASKW) msk_q <= msk_rest;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_is_hdr) && $stable(out_offset) && $stable(out_field)); // R12
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid && out_word == $past(in_word)); // R12
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_lock_acq, out_lock_rel, out_ext_err})); // R8
  AST_PAYLOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_hdr |-> !(out_lock_acq || out_lock_rel || out_ext_err)); // R10
  AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
    accept && pending |=> !out_is_hdr && rem_q == $past(rem_q) - 16'd1); // R10
  AST_MASK_TRACK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OPC_SETCL || mode_q == OPC_MASKW) && pending |-> $countones(msk_q) == int'(rem_q)); // R4
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rem_q == '0 && cls_q == '0 && !out_valid); // R11
endmodule

// File: tb/cmd_hdr_parser_tb.sv
module cmd_hdr_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_word, out_addr, out_word;
  logic        out_is_hdr, out_lock_acq, out_lock_rel, out_ext_err;
  logic [3:0]  out_opcode;
  logic [9:0]  out_class;
  logic [11:0] out_offset;
  logic [15:0] out_field;

  always #4 clk = ~clk;

  cmd_hdr_parser dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_hdr(out_is_hdr),
    .out_opcode(out_opcode), .out_class(out_class), .out_offset(out_offset),
    .out_field(out_field), .out_addr(out_addr), .out_lock_acq(out_lock_acq),
    .out_lock_rel(out_lock_rel), .out_ext_err(out_ext_err), .out_word(out_word)
  );

  typedef struct packed {
    logic        hdr;
    logic [3:0]  op;
    logic [9:0]  cls;
    logic [11:0] ofs;
    logic [15:0] fld;
    logic [31:0] addr;
    logic        acq, rel, err;
    logic [31:0] word;
  } rec_t;

  rec_t        expq[$];
  logic [31:0] stim[$];
  int          checks = 0, fails = 0, cyc = 0;
  int          m_rem = 0, m_op = 0, m_base = 0, m_step = 0, m_cls = 0;
  logic [15:0] m_mask = '0;
  logic [15:0] lfsr = 16'hACE1;
  int          stall_thr = 0, gap_thr = 0;
  bit          timed_out = 0;

  function automatic int pop16(logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic string tag_of(rec_t r);
    string t;
    case (r.op)
      4'h0: t = "R2";
      4'h1, 4'h2: t = "R3";
      4'h3: t = "R4";
      4'h4: t = "R5";
      4'h5: t = "R6";
      4'h6: t = "R7";
      4'hE: t = "R8";
      default: t = "R9";
    endcase
    return r.hdr ? {"R1,", t} : {"R10,", t};
  endfunction

  function automatic rec_t model(logic [31:0] w);
    rec_t r = '0;
    r.word = w;
    if (m_rem == 0) begin
      r.hdr = 1'b1;
      r.op  = w[31:28];
      if (r.op == 4'h0) m_cls = int'(w[15:6]);
      r.cls = 10'(m_cls);
      if (r.op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h6}) r.ofs = w[27:16];
      case (r.op)
        4'h0: begin r.fld = {10'b0, w[5:0]}; m_rem = pop16({10'b0, w[5:0]}); end
        4'h1, 4'h2: begin r.fld = w[15:0]; m_rem = int'(w[15:0]); end
        4'h3: begin r.fld = w[15:0]; m_rem = pop16(w[15:0]); end
        4'h4: r.fld = w[15:0];
        4'h5: r.addr = w << 4;
        4'h6: begin r.fld = w[15:0]; m_rem = 1; end
        4'hE: begin
          r.fld = {8'b0, w[7:0]};
          r.acq = (w[27:24] == 4'd0);
          r.rel = (w[27:24] == 4'd1);
          r.err = (w[27:24] > 4'd1);
        end
        default: ;
      endcase
      m_op   = int'(w[31:28]);
      m_base = int'(w[27:16]);
      m_step = m_base;
      m_mask = (r.op == 4'h0) ? {10'b0, w[5:0]} : w[15:0];
    end else begin
      r.op  = 4'(m_op);
      r.cls = 10'(m_cls);
      m_rem = m_rem - 1;
      r.fld = 16'(m_rem);
      if (m_op == 1) begin
        r.ofs  = 12'(m_step);
        m_step = (m_step + 1) % 4096;
      end else if (m_op == 0 || m_op == 3) begin
        for (int k = 0; k < 16; k++) begin
          if (m_mask[k]) begin
            r.ofs = 12'((m_base + k) % 4096);
            m_mask[k] = 1'b0;
            break;
          end
        end
      end else begin
        r.ofs = 12'(m_base);
      end
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    rec_t act;
    act = {out_is_hdr, out_opcode, out_class, out_offset, out_field, out_addr,
           out_lock_acq, out_lock_rel, out_ext_err, out_word};
    chk(out_valid === (expq.size() != 0), "R12", "out_valid vs pending records",
        128'(out_valid), 128'(expq.size() != 0));
    if (out_valid && expq.size() != 0)
      chk(act === expq[0], tag_of(expq[0]), "record", 128'(act), 128'(expq[0]));
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (int'(lfsr[3:0]) >= stall_thr);
    in_valid  = (stim.size() != 0) && (int'(lfsr[7:4]) >= gap_thr);
    in_word   = (stim.size() != 0) ? stim[0] : 32'h0;
    if (out_valid && out_ready && expq.size() != 0) void'(expq.pop_front());
    #1;
    chk(in_ready === (!out_valid || out_ready), "R12", "in_ready",
        128'(in_ready), 128'(!out_valid || out_ready));
    if (in_valid && in_ready) expq.push_back(model(stim.pop_front()));
  endtask

  task automatic run_stream();
    while ((stim.size() != 0 || expq.size() != 0) && !timed_out) begin
      @(negedge clk);
      step();
      cyc++;
      if (cyc > 100000) begin
        timed_out = 1;
        fails++;
        checks++;
        $display("FAIL R12 watchdog actual=%0d expected=<100000", cyc);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expq.delete(); stim.delete();
    m_rem = 0; m_cls = 0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'(0));
    chk(in_ready === 1'b1, "R11", "in_ready after reset", 128'(in_ready), 128'(1));
  endtask

  task automatic load_main();
    stim.push_back(32'h0010_48E9);              // set-class cls 0x123 ofs 0x010 mask 0x29
    for (int i = 0; i < 3; i++) stim.push_back(32'hE000_0010 + 32'(i));
    stim.push_back(32'h0000_A940);              // set-class cls 0x2A5, mask 0
    stim.push_back(32'h1FFE_0004);              // incr ofs 0xFFE count 4 (wrap)
    for (int i = 0; i < 4; i++) stim.push_back(32'hD000_0000 + 32'(i));
    stim.push_back(32'h2040_0003);              // nonincr ofs 0x40 count 3
    for (int i = 0; i < 3; i++) stim.push_back(32'h5ABC_0000 + 32'(i));
    stim.push_back(32'h1123_0000);              // incr count 0
    stim.push_back(32'h3100_8001);              // masked ofs 0x100 bits 0,15
    stim.push_back(32'hE100_0005); stim.push_back(32'h0000_0001);
    stim.push_back(32'h3200_0000);              // masked, empty mask
    stim.push_back(32'h4020_BEEF);              // immediate
    stim.push_back(32'h5123_4567);              // restart
    stim.push_back(32'h6033_8ABC);              // gather
    stim.push_back(32'hE000_00FF);              // payload: gather address
    stim.push_back(32'hE000_0007);              // lock acquire
    stim.push_back(32'hE100_0003);              // lock release
    stim.push_back(32'hE500_00FF);              // unknown sub-op
    stim.push_back(32'h7FFF_FFFF);              // unlisted opcodes
    stim.push_back(32'hF000_1234);
    stim.push_back(32'h8ABC_DEF0);
    stim.push_back(32'h0FFF_003F);              // set-class full 6-bit mask, ofs 0xFFF
    for (int i = 0; i < 6; i++) stim.push_back(32'hA000_0000 + 32'(i));
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_word = '0;
    do_reset();
    // R1..R10: clean stream, no stalls
    stall_thr = 0; gap_thr = 0;
    load_main();
    run_stream();
    // R12: same stream with output stalls and input gaps
    stall_thr = 6; gap_thr = 5;
    load_main();
    run_stream();
    // R11: reset partway through a payload run
    stall_thr = 0; gap_thr = 0;
    stim.push_back(32'h1050_0005);
    stim.push_back(32'h0000_0001); stim.push_back(32'h0000_0002);
    run_stream();
    do_reset();
    stim.push_back(32'hE000_0009);              // must be a header after reset
    stim.push_back(32'h4011_0022);              // immediate, class must read 0
    run_stream();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule